// File: doc/BRIEF.md
# Dual-Bank Pointer Addressing Unit

This unit turns a compact 5-bit access code into a RAM bank and word address for a DSP datapath. Six 8-bit pointer registers are kept, three per bank. A fourth index in each bank is not a register: it selects one of the first four words of that bank directly. An access may step the selected pointer up or down after use. A loop-size field can confine that step to a power-of-two window, which suits circular sample buffers.

A second-level mode chains two reads. The RAM word that the pointer addresses is presented as a program-memory address, and the word is written back incremented by one. This lets a table cursor kept in RAM advance on each fetch. Pointers can be loaded and read back through dedicated ports. The RAM arrays and the instruction decoder sit outside the unit. RAM reads are combinational, and RAM writes commit on the clock edge that ends the access.

Top module: `dual_bank_ptr_unit`

## Requirements
- R1: The access code packs the pointer index in bits 1:0, the bank in bit 2 and the modifier in bits 4:3. For index 0 to 2, `ram_bank` equals bit 2 and `ram_addr` equals the current value of the selected pointer.
- R2: For a first-level access on index 0 to 2, the selected pointer changes at the next clock edge according to the modifier:
  - modifier 0 leaves it unchanged;
  - modifier 1 adds one;
  - modifier 2 subtracts one;
  - modifier 3 adds one modulo 256 and ignores the loop size.
- R3: For index 3 in either bank, `ram_addr` equals the modifier value (0 to 3), and no pointer changes.
- R4: When `loop_size` L is non-zero, modifiers 1 and 2 wrap within 2^L. Bits 7:L of the pointer stay fixed. For example, with L=4, 0x2F steps up to 0x20 and 0x20 steps down to 0x2F.
- R5: A second-level access raises `pm_valid` and `ram_we`, drives `pm_addr` with `ram_rdata`, and drives `ram_wdata` with `ram_rdata`+1 (modulo 2^16) at the same bank and address. No pointer changes.
- R6: A second-level access on index 0 to 2 with a non-zero modifier is refused. `pm_valid` and `ram_we` stay low, and no pointer changes.
- R7: When `ld_en` is high, `ld_sel` = {bank, index} loads `ld_data` into the selected pointer at the clock edge. A load aimed at index 3 is ignored. `rd_data` shows the pointer chosen by `rd_sel` and reads 0 for index 3.
- R8: When a load and a post-modify target the same pointer in one cycle, the loaded value wins.
- R9: Reset (active-low) clears every pointer to 0.
- R10: While `acc_valid` is low, `ram_we` and `pm_valid` stay low and no pointer is modified by an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is performed this cycle |
| acc_code | input | 5 | {modifier[1:0], bank, index[1:0]} |
| acc_deep | input | 1 | Second-level access |
| loop_size | input | 3 | Wrap window exponent, 0 disables wrap |
| ram_rdata | input | 16 | Word read from the addressed RAM |
| ld_en | input | 1 | Pointer load strobe |
| ld_sel | input | 3 | {bank, index} of the pointer to load |
| ld_data | input | 8 | Load value |
| rd_sel | input | 3 | {bank, index} of the pointer to read |
| ram_bank | output | 1 | Addressed bank |
| ram_addr | output | 8 | Addressed RAM word |
| ram_we | output | 1 | Write-back strobe for second-level access |
| ram_wdata | output | 16 | Write-back value |
| pm_valid | output | 1 | Program-memory address is valid |
| pm_addr | output | 16 | Program-memory address |
| rd_data | output | 8 | Selected pointer value |

## Verification
A pointer that holds a wrong value shows up on `ram_addr` at the next access that uses it, and on `rd_data` in the cycle it is selected. A step error therefore appears one clock after the faulty edge. A wrap-mask fault corrupts only the pointer bits above L, and only once a walk crosses a window boundary, so walks are run across boundaries for several loop sizes. Refused or idle accesses are checked combinationally for stray `ram_we` and `pm_valid`. The following cycle confirms that the pointers did not move.

// File: rtl/dual_bank_ptr_unit.sv
module dual_bank_ptr_unit #(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 16,
  parameter int LOOP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [4:0]        acc_code,
  input  logic              acc_deep,
  input  logic [LOOP_W-1:0] loop_size,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic              ld_en,
  input  logic [2:0]        ld_sel,
  input  logic [PTR_W-1:0]  ld_data,
  input  logic [2:0]        rd_sel,
  output logic              ram_bank,
  output logic [PTR_W-1:0]  ram_addr,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              pm_valid,
  output logic [DATA_W-1:0] pm_addr,
  output logic [PTR_W-1:0]  rd_data
);
  localparam int NSLOT = 6;

  logic [NSLOT-1:0][PTR_W-1:0] ptr_q;

  logic [1:0] a_idx, a_mod;
  logic       a_fixed, ld_fixed, rd_fixed;
  logic [2:0] a_slot, ld_slot, rd_slot;
  logic [PTR_W-1:0] cur, win_mask, up, dn, nxt;
  logic       step_en, deep_ok;

  assign {a_mod, ram_bank, a_idx} = acc_code;
  assign a_fixed  = (a_idx == 2'd3);
  assign ld_fixed = (ld_sel[1:0] == 2'd3);
  assign rd_fixed = (rd_sel[1:0] == 2'd3);

  assign a_slot  = (a_fixed  ? 3'd0 : {1'b0, a_idx})       + (ram_bank  ? 3'd3 : 3'd0);
  assign ld_slot = (ld_fixed ? 3'd0 : {1'b0, ld_sel[1:0]}) + (ld_sel[2] ? 3'd3 : 3'd0);
  assign rd_slot = (rd_fixed ? 3'd0 : {1'b0, rd_sel[1:0]}) + (rd_sel[2] ? 3'd3 : 3'd0);

  assign cur      = ptr_q[a_slot];
  assign ram_addr = a_fixed ? PTR_W'(a_mod) : cur;
  assign rd_data  = rd_fixed ? '0 : ptr_q[rd_slot];

  assign win_mask = (loop_size == '0) ? '1 : ((PTR_W'(1) << loop_size) - PTR_W'(1));
  assign up = cur + PTR_W'(1);
  assign dn = cur - PTR_W'(1);

  always_comb begin
    case (a_mod)
      2'd1:    nxt = (cur & ~win_mask) | (up & win_mask);
      2'd2:    nxt = (cur & ~win_mask) | (dn & win_mask);
      2'd3:    nxt = up;
      default: nxt = cur;
    endcase
  end

  assign step_en   = acc_valid & ~acc_deep & ~a_fixed & (a_mod != 2'd0);
  assign deep_ok   = acc_valid & acc_deep & (a_fixed | (a_mod == 2'd0));
  assign ram_we    = deep_ok;
  assign pm_valid  = deep_ok;
  assign pm_addr   = ram_rdata;
  assign ram_wdata = ram_rdata + DATA_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (ld_en && !ld_fixed && ld_slot == 3'(s))
          ptr_q[s] <= ld_data;
        else if (step_en && a_slot == 3'(s))
          ptr_q[s] <= nxt;
      end
    end
  end
endmodule

// File: rtl/dual_bank_ptr_unit_chk.sv
module dual_bank_ptr_unit_chk #(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 16,
  parameter int LOOP_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_valid,
  input logic [4:0]            acc_code,
  input logic                  acc_deep,
  input logic [LOOP_W-1:0]     loop_size,
  input logic [DATA_W-1:0]     ram_rdata,
  input logic                  ld_en,
  input logic [2:0]            rd_sel,
  input logic [PTR_W-1:0]      ram_addr,
  input logic                  ram_we,
  input logic [DATA_W-1:0]     ram_wdata,
  input logic                  pm_valid,
  input logic [DATA_W-1:0]     pm_addr,
  input logic [PTR_W-1:0]      rd_data,
  input logic [5:0][PTR_W-1:0] ptr_q
);
  logic [1:0] idx, md;
  logic [2:0] slot;
  assign idx  = acc_code[1:0];
  assign md   = acc_code[4:3];
  assign slot = (idx == 2'd3) ? 3'd0 : ({1'b0, idx} + (acc_code[2] ? 3'd3 : 3'd0));

  assert_fixed_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && idx == 2'd3 |-> ram_addr == PTR_W'(md));
  assert_fixed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && idx == 2'd3 && !ld_en |=> $stable(ptr_q));
  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_deep && idx != 2'd3 && md == 2'd1 && loop_size == '0 && !ld_en
    |=> ptr_q[$past(slot)] == PTR_W'($past(ram_addr) + PTR_W'(1)));
  assert_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_wdata == DATA_W'(ram_rdata + DATA_W'(1)) && pm_addr == ram_rdata && pm_valid);
  assert_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_deep && idx != 2'd3 && md != 2'd0 |-> !ram_we && !pm_valid);
  assert_fixed_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel[1:0] == 2'd3 |-> rd_data == '0);
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ptr_q == '0);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !ram_we && !pm_valid);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid && !ld_en |=> $stable(ptr_q));
endmodule

bind dual_bank_ptr_unit dual_bank_ptr_unit_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W), .LOOP_W(LOOP_W)) chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_code(acc_code), .acc_deep(acc_deep),
  .loop_size(loop_size), .ram_rdata(ram_rdata), .ld_en(ld_en), .rd_sel(rd_sel),
  .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .pm_valid(pm_valid),
  .pm_addr(pm_addr), .rd_data(rd_data), .ptr_q(ptr_q)
);

// File: tb/tb_dual_bank_ptr_unit.sv
module tb_dual_bank_ptr_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_deep = 0, ld_en = 0;
  logic [4:0] acc_code = 0;
  logic [2:0] loop_size = 0, ld_sel = 0, rd_sel = 0;
  logic [15:0] ram_rdata = 0;
  logic [7:0] ld_data = 0;
  logic ram_bank, ram_we, pm_valid;
  logic [7:0] ram_addr, rd_data;
  logic [15:0] ram_wdata, pm_addr;

  int vectors = 0, fails = 0;
  int mp [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_ptr_unit dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_code(acc_code), .acc_deep(acc_deep),
    .loop_size(loop_size), .ram_rdata(ram_rdata), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .rd_sel(rd_sel), .ram_bank(ram_bank), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .pm_valid(pm_valid), .pm_addr(pm_addr), .rd_data(rd_data)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int wrap_step(input int v, input int l, input int dir);
    int w, lo;
    if (l == 0) return (v + dir + 256) % 256;
    w  = 1 << l;
    lo = v % w;
    return v - lo + ((lo + dir + w) % w);
  endfunction

  task automatic cyc(input bit v, input int code, input bit deep, input int l, input int rdat,
                     input bit le, input int ls, input int ld, input int rs, input string tag);
    int idx, md, bk, slot, ok2;
    @(negedge clk);
    acc_valid = v; acc_code = 5'(code); acc_deep = deep; loop_size = 3'(l);
    ram_rdata = 16'(rdat); ld_en = le; ld_sel = 3'(ls); ld_data = 8'(ld); rd_sel = 3'(rs);
    #1;
    idx = code & 3; bk = (code >> 2) & 1; md = (code >> 3) & 3; slot = bk * 4 + idx;
    ok2 = (v && deep && (idx == 3 || md == 0)) ? 1 : 0;
    cmp(tag, "rd_data", rd_data, mp[rs]);
    if (v) begin
      cmp(tag, "ram_bank", ram_bank, bk);
      cmp(tag, "ram_addr", ram_addr, (idx == 3) ? md : mp[slot]);
    end
    cmp(tag, "ram_we", ram_we, ok2);
    cmp(tag, "pm_valid", pm_valid, ok2);
    if (ok2 != 0) begin
      cmp(tag, "pm_addr", pm_addr, rdat & 16'hFFFF);
      cmp(tag, "ram_wdata", ram_wdata, (rdat + 1) & 16'hFFFF);
    end
    @(posedge clk);
    if (v && !deep && idx != 3) begin
      if (md == 1) mp[slot] = wrap_step(mp[slot], l, 1);
      else if (md == 2) mp[slot] = wrap_step(mp[slot], l, -1);
      else if (md == 3) mp[slot] = (mp[slot] + 1) % 256;
    end
    if (le && (ls & 3) != 3) mp[ls] = ld & 8'hFF;
  endtask

  function automatic int cd(input int md, input int bk, input int idx);
    return (md << 3) | (bk << 2) | idx;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired, R10 run did not end");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mp[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, i, "R9");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 1, i, 16 * i + 5, i, "R7");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, i, "R7");
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 3; p++)
        for (int m = 0; m < 4; m++) begin
          cyc(1, cd(m, b, p), 0, 0, 0, 0, 0, 0, b * 4 + p, "R1");
          cyc(1, cd(0, b, p), 0, 0, 0, 0, 0, 0, b * 4 + p, "R2");
        end
    cyc(0, 0, 0, 0, 0, 1, 1, 8'h2E, 1, "R4");
    for (int k = 0; k < 4; k++) cyc(1, cd(1, 0, 1), 0, 4, 0, 0, 0, 0, 1, "R4");
    for (int k = 0; k < 4; k++) cyc(1, cd(2, 0, 1), 0, 4, 0, 0, 0, 0, 1, "R4");
    cyc(0, 0, 0, 0, 0, 1, 5, 8'hFF, 5, "R2");
    cyc(1, cd(3, 1, 1), 0, 2, 0, 0, 0, 0, 5, "R2");
    cyc(1, cd(0, 1, 1), 0, 0, 0, 0, 0, 0, 5, "R2");
    for (int b = 0; b < 2; b++)
      for (int m = 0; m < 4; m++) cyc(1, cd(m, b, 3), 0, 0, 0, 0, 0, 0, b * 4, "R3");
    for (int b = 0; b < 2; b++)
      for (int m = 0; m < 4; m++) cyc(1, cd(m, b, 3), 1, 0, 16'h1234 + m, 0, 0, 0, b * 4 + 2, "R5");
    cyc(1, cd(0, 0, 2), 1, 0, 16'hFFFF, 0, 0, 0, 2, "R5");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 2, "R5");
    for (int m = 1; m < 4; m++) cyc(1, cd(m, 1, 0), 1, 0, 16'h0042, 0, 0, 0, 4, "R6");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 4, "R6");
    cyc(1, cd(1, 0, 0), 0, 0, 0, 1, 0, 8'h77, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    for (int k = 0; k < 4; k++) cyc(0, cd(1, 0, k), 1, 0, 16'h5555, 0, 0, 0, k, "R10");
    for (int k = 0; k < 3000; k++) begin
      int c, l;
      c = int'($urandom_range(0, 31));
      l = int'($urandom_range(0, 7));
      cyc($urandom_range(0, 3) != 0, c, $urandom_range(0, 3) == 0, l, int'($urandom_range(0, 65535)),
          $urandom_range(0, 7) == 0, int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
          int'($urandom_range(0, 7)), ((c & 3) == 3) ? "R3" : "R4");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule